// File: doc/BRIEF.md
# Double-Binary Tail-Biting Convolutional Encoder

This block encodes a block of data couples with an 8-state circular recursive systematic convolutional code. Each trellis step consumes two input bits (A, B) and yields two parity bits, Y and W. No tail bits are added. Instead the trellis is closed on itself: the encoding pass starts in a state chosen so that the register returns to that same state after the last couple.

Couples arrive one per cycle and are stored in an internal buffer. While they are stored, a first pass runs from the all-zero state. When the block closes, the circulation state is derived from the final state of that pass and from the block length modulo 7. A second pass then replays the buffer from the circulation state and streams the parity bits out, one pair per cycle. A length that is a multiple of 7 has no unique circulation state. Such a block is dropped and an error pulse is raised.

Top module: `dbtb_encoder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and len_err is 0.
- R2: With the state taken as bits (s1,s2,s3) and feedback f = A^B^s1^s3, each step yields Y = f^s2^s3 and W = f^s3, and moves to the state (f, s1^B, s2^B).
- R3: The encoding pass starts in the unique state from which a block of N steps ends in that same state, and it returns to that state after the last couple.
- R4: A block of N couples yields exactly N output pairs in input order. out_last is high on the Nth pair only.
- R5: The first output pair appears in the cycle after the last couple is accepted. in_ready stays low while out_valid is high and returns high in the cycle after out_last.
- R6: A block whose length N is a multiple of 7 produces no output. len_err pulses for one cycle after its last couple, and in_ready stays high.
- R7: A block ends when its MAX_N-th couple is accepted, whether or not in_last is set.
- R8: in_valid while in_ready is low has no effect: the output stream of the current block is unchanged and no new block is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Couple present |
| in_a | input | 1 | First bit of the couple |
| in_b | input | 1 | Second bit of the couple |
| in_last | input | 1 | Couple closes the block |
| in_ready | output | 1 | Encoder accepts couples |
| out_valid | output | 1 | Parity pair valid |
| out_y | output | 1 | Y parity bit |
| out_w | output | 1 | W parity bit |
| out_last | output | 1 | Final pair of the block |
| len_err | output | 1 | Block dropped: length a multiple of 7 |

## Verification
Two events can meet in one cycle. The buffer can fill and in_last can arrive on the same couple. A block can also close on a length that is a multiple of 7, which turns its end into a rejection instead of the start of the encoding pass. The bench provokes the first by sending MAX_N couples with in_last on the final one, and again with in_last never set. It provokes the second with lengths 7 and 14. In each case it judges the result by the count of output pairs, the position of out_last, the len_err pulses and the parity stream. The parity stream is compared with a model that finds the circulation state by trying all eight start states.

// File: rtl/dbtb_encoder.sv
module dbtb_encoder #(
  parameter int MAX_N = 32,
  localparam int CW = $clog2(MAX_N)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_a,
  input  logic in_b,
  input  logic in_last,
  output logic in_ready,
  output logic out_valid,
  output logic out_y,
  output logic out_w,
  output logic out_last,
  output logic len_err
);

  function automatic logic [2:0] step(input logic [2:0] s, input logic a, input logic b);
    logic f;
    f = a ^ b ^ s[2] ^ s[0];
    return {f, s[2] ^ b, s[1] ^ b};
  endfunction

  function automatic logic [2:0] circ(input logic [2:0] k, input logic [2:0] z);
    logic [2:0] h, r;
    r = '0;
    for (int c = 0; c < 8; c++) begin
      h = 3'(c);
      for (int j = 0; j < 6; j++)
        if (3'(j) < k) h = {h[2] ^ h[0], h[2], h[1]};
      if ((3'(c) ^ h) == z) r = 3'(c);
    end
    return r;
  endfunction

  logic [1:0]    cpl_q [MAX_N];
  logic          enc;
  logic [CW-1:0] wr, rd, last_idx;
  logic [2:0]    m7, pre, st;
  logic          err_q;

  wire        acc     = in_valid && !enc;
  wire        blk_end = acc && (in_last || wr == CW'(MAX_N - 1));
  wire [2:0]  m7_n    = (m7 == 3'd6) ? 3'd0 : m7 + 3'd1;
  wire [2:0]  pre_n   = step(pre, in_a, in_b);
  wire [1:0]  cur     = cpl_q[rd];
  wire        fb      = cur[1] ^ cur[0] ^ st[2] ^ st[0];

  assign in_ready  = !enc;
  assign out_valid = enc;
  assign out_y     = enc && (fb ^ st[1] ^ st[0]);
  assign out_w     = enc && (fb ^ st[0]);
  assign out_last  = enc && (rd == last_idx);
  assign len_err   = err_q;

  always_ff @(posedge clk)
    if (acc) cpl_q[wr] <= {in_a, in_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc <= 1'b0; wr <= '0; rd <= '0; last_idx <= '0;
      m7 <= '0; pre <= '0; st <= '0; err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (blk_end) begin
        wr <= '0; m7 <= '0; pre <= '0;
        if (m7_n == 3'd0) err_q <= 1'b1;
        else begin
          enc <= 1'b1; rd <= '0; last_idx <= wr;
          st <= circ(m7_n, pre_n);
        end
      end else if (acc) begin
        wr <= wr + 1'b1; m7 <= m7_n; pre <= pre_n;
      end
      if (enc) begin
        st <= step(st, cur[1], cur[0]);
        rd <= rd + 1'b1;
        if (rd == last_idx) enc <= 1'b0;
      end
    end
  end

endmodule

module dbtb_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_last,
  input logic       len_err,
  input logic [2:0] st
);
  logic       ov_q;
  logic [2:0] st0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin ov_q <= 1'b0; st0 <= '0; end
    else begin
      ov_q <= out_valid;
      if (out_valid && !ov_q) st0 <= st;
    end
  end

  assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready);
  assert_ready_back_R5: assert property (@(posedge clk) disable iff (!rst_n) out_last |=> in_ready);
  assert_last_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid);
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n) len_err |=> !len_err);
  assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rst_n) len_err |-> (!out_valid && in_ready));
  assert_circular_R3: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_last) |=> st == st0);
endmodule

bind dbtb_encoder dbtb_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_last(out_last), .len_err(len_err), .st(st)
);

// File: tb/dbtb_encoder_test.sv
`timescale 1ns/1ps
module dbtb_encoder_test;
  localparam int MAX_N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_a = 1'b0, in_b = 1'b0, in_last = 1'b0;
  logic in_ready, out_valid, out_y, out_w, out_last, len_err;

  int total = 0, bad = 0, ng = 0, nerr = 0;
  bit done = 0;
  bit ra [MAX_N], rb [MAX_N], gy [MAX_N+8], gw [MAX_N+8], gl [MAX_N+8];

  always #4 clk = ~clk;

  dbtb_encoder #(.MAX_N(MAX_N)) uut (.*);

  always @(negedge clk) begin
    if (out_valid) begin
      if (ng < MAX_N + 8) begin gy[ng] = out_y; gw[ng] = out_w; gl[ng] = out_last; end
      ng++;
    end
    if (len_err) nerr++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic int end_state(input int c, input int n);
    bit s1, s2, s3, f;
    s1 = c[2]; s2 = c[1]; s3 = c[0];
    for (int i = 0; i < n; i++) begin
      f = ra[i] ^ rb[i] ^ s1 ^ s3;
      s3 = s2 ^ rb[i]; s2 = s1 ^ rb[i]; s1 = f;
    end
    return {s1, s2, s3};
  endfunction

  task automatic run_block(input int n, input bit use_last, input bit hammer, input string tag);
    int c0, bad_pos, nlast;
    bit s1, s2, s3, f, ey, ew;
    ng = 0; nerr = 0;
    for (int i = 0; i < n; i++) begin ra[i] = 1'($urandom); rb[i] = 1'($urandom); end
    for (int i = 0; i < n; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_a = ra[i]; in_b = rb[i];
      in_last = use_last && (i == n - 1);
      @(negedge clk);
    end
    if (n % 7 != 0)
      check(out_valid && !in_ready, "R5 first pair after last couple", {out_valid, in_ready}, 2);
    in_valid = hammer; in_last = hammer;
    while (!in_ready) begin
      if (hammer) begin in_a = 1'($urandom); in_b = 1'($urandom); end
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    if (n % 7 == 0) begin
      check(ng == 0 && nerr == 1, {"R6 rejected length ", tag}, ng * 10 + nerr, 1);
      return;
    end
    c0 = -1;
    for (int c = 0; c < 8; c++) if (end_state(c, n) == c) c0 = c;
    check(ng == n && nerr == 0, {"R4 pair count ", tag}, ng, n);
    bad_pos = -1; nlast = 0;
    s1 = c0[2]; s2 = c0[1]; s3 = c0[0];
    for (int i = 0; i < n; i++) begin
      f = ra[i] ^ rb[i] ^ s1 ^ s3;
      ey = f ^ s2 ^ s3; ew = f ^ s3;
      if (bad_pos < 0 && (gy[i] != ey || gw[i] != ew)) bad_pos = i;
      s3 = s2 ^ rb[i]; s2 = s1 ^ rb[i]; s1 = f;
      if (gl[i]) nlast++;
    end
    check(bad_pos < 0, {"R2 R3 parity stream ", tag}, bad_pos, -1);
    check(nlast == 1 && gl[n-1], {"R4 out_last position ", tag}, nlast, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid && !len_err, "R1 reset state", {in_ready, out_valid, len_err}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && !len_err, "R1 after reset", {in_ready, out_valid, len_err}, 4);
    run_block(1, 1, 0, "n=1");
    run_block(8, 1, 0, "n=8");
    run_block(7, 1, 0, "n=7");
    run_block(14, 1, 0, "n=14");
    run_block(MAX_N, 0, 0, "R7 full no last");
    run_block(MAX_N, 1, 0, "R7 full with last");
    run_block(13, 1, 1, "R8 hammer");
    run_block(6, 1, 1, "R8 hammer short");
    for (int k = 0; k < 12; k++) begin
      int n;
      n = 1 + int'($urandom_range(MAX_N - 1));
      run_block(n, 1, k % 3 == 0, $sformatf("random n=%0d", n));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule